// File: doc/BRIEF.md
# Walk and Dual-Slope Time Encoder

This block is the digital model of one channel's time-encoding output. It runs from a fast clock and drives a single serial line that a multi-hit TDC channel and the multiplicity logic both listen to. A discriminator hit first produces a short walk marker, which carries the arrival time. After the analogue value has been held at the end of the gate, a hold-valid strobe starts a dual-slope conversion. The line then goes high for a fixed rundown period, common to every channel, followed by a runup period proportional to the amplitude. The width of that second pulse therefore encodes the amplitude, and one TDC channel captures both quantities.

The controller is a six-state machine. From IDLE, a hit moves it to WALK, which drives the line high for 2 cycles. WALK moves to GAP, which holds the line low for 4 cycles, and GAP moves to ARMED. In ARMED the line stays low and the block waits for the hold strobe. A strobe moves it to RUNDOWN, where the line is high for 256 cycles. RUNDOWN moves to RUNUP when the product amplitude × scale is non-zero, and back to IDLE when it is zero. RUNUP keeps the line high for that product in cycles and then returns to IDLE. Busy is high in every state except IDLE.

Top module: `walk_time_encoder`

## Requirements
- R1: After reset, `wt_line` and `busy` are both low and the block is idle.
- R2: A `disc_hit` sampled high while idle makes `wt_line` high for exactly 2 cycles, starting in the cycle after the hit.
- R3: After the walk marker, `wt_line` stays low for at least 4 cycles. A `hold_valid` strobe that arrives during the walk marker or during those 4 low cycles is ignored.
- R4: Once the 4 low cycles have elapsed, the first `hold_valid` sampled high starts the time pulse. `wt_line` rises in the next cycle.
- R5: The time pulse lasts exactly 256 + `amp_code` × `runup_scale` cycles. Both inputs are captured on the cycle the strobe is accepted.
- R6: When `amp_code` or `runup_scale` is zero, the time pulse is exactly 256 cycles wide.
- R7: `busy` is high from the first cycle of the walk marker through the last cycle of the time pulse, and low in the following cycle.
- R8: `hold_valid` strobes, and changes of `amp_code` or `runup_scale`, that occur during the time pulse do not alter its width.
- R9: A `disc_hit` while busy, or a `hold_valid` while idle, has no effect on `wt_line` or `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_hit | input | 1 | Discriminator hit, sampled each cycle |
| hold_valid | input | 1 | Held amplitude ready strobe |
| amp_code | input | 12 | Held amplitude code |
| runup_scale | input | 4 | Runup cycles per amplitude unit |
| wt_line | output | 1 | Combined walk/time serial line |
| busy | output | 1 | Channel occupied from walk to end of time pulse |

## Verification
The main function is exercised with random amplitudes and scales, random strobe delays after the gap, and directed cases with zero amplitude, zero scale and the full-scale product. The random cases separate correct capture-and-multiply from fixed-width or truncated counting. The zero cases confirm that the runup phase is skipped and the width falls back to the bare rundown. Other events inject early strobes, strobes and hits during the pulse, and amplitude changes after capture. These show whether the block samples its inputs only at the accepted strobe and ignores them at every other time.

// File: rtl/wte_pkg.sv
package wte_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_WALK    = 3'd1,
        S_GAP     = 3'd2,
        S_ARMED   = 3'd3,
        S_RUNDOWN = 3'd4,
        S_RUNUP   = 3'd5
    } wte_state_t;

endpackage

// File: rtl/wte_period_counter.sv
module wte_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt == '0);

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R5

endmodule

// File: rtl/wte_runup_calc.sv
module wte_runup_calc #(
    parameter int AMP_W   = 12,
    parameter int SCALE_W = 4,
    localparam int PROD_W = AMP_W + SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [AMP_W-1:0]   amp_code,
    input  logic [SCALE_W-1:0] runup_scale,
    output logic [PROD_W-1:0]  prod
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else if (capture) begin
            prod <= PROD_W'(amp_code) * PROD_W'(runup_scale);
        end
    end

    AST_PROD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(prod)); // R8

endmodule

// File: rtl/wte_ctrl.sv
module wte_ctrl
    import wte_pkg::*;
#(
    parameter int PROD_W      = 16,
    parameter int CNT_W       = 16,
    parameter int WALK_CYC    = 2,
    parameter int GAP_CYC     = 4,
    parameter int RUNDOWN_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disc_hit,
    input  logic              hold_valid,
    input  logic              cnt_zero,
    input  logic [PROD_W-1:0] prod,
    output wte_state_t        state,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              capture,
    output logic              wt_line,
    output logic              busy
);

    wte_state_t state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n  = state;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (disc_hit) begin
                    state_n  = S_WALK;
                    load     = 1'b1;
                    load_val = CNT_W'(WALK_CYC - 1);
                end
            end
            S_WALK: begin
                if (cnt_zero) begin
                    state_n  = S_GAP;
                    load     = 1'b1;
                    load_val = CNT_W'(GAP_CYC - 1);
                end
            end
            S_GAP: begin
                if (cnt_zero) begin
                    state_n = S_ARMED;
                end
            end
            S_ARMED: begin
                if (hold_valid) begin
                    state_n  = S_RUNDOWN;
                    load     = 1'b1;
                    load_val = CNT_W'(RUNDOWN_CYC - 1);
                    capture  = 1'b1;
                end
            end
            S_RUNDOWN: begin
                if (cnt_zero) begin
                    if (prod == '0) begin
                        state_n = S_IDLE;
                    end else begin
                        state_n  = S_RUNUP;
                        load     = 1'b1;
                        load_val = CNT_W'(prod) - CNT_W'(1);
                    end
                end
            end
            S_RUNUP: begin
                if (cnt_zero) begin
                    state_n = S_IDLE;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_comb begin
        wt_line = 1'b0;
        busy    = 1'b1;
        unique case (state)
            S_IDLE:    busy    = 1'b0;
            S_WALK:    wt_line = 1'b1;
            S_GAP:     wt_line = 1'b0;
            S_ARMED:   wt_line = 1'b0;
            S_RUNDOWN: wt_line = 1'b1;
            S_RUNUP:   wt_line = 1'b1;
            default:   busy    = 1'b0;
        endcase
    end

    AST_HIT_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && disc_hit) |=> (state == S_WALK)); // R2
    AST_NO_EARLY_CONVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_WALK || state == S_GAP) |=> (state != S_RUNDOWN)); // R3
    AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && hold_valid) |=> (state == S_RUNDOWN)); // R4
    AST_PULSE_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUNDOWN || state == S_RUNUP) |=> (state != S_WALK && state != S_ARMED)); // R9

endmodule

// File: rtl/walk_time_encoder.sv
module walk_time_encoder
    import wte_pkg::*;
#(
    parameter int AMP_W       = 12,
    parameter int SCALE_W     = 4,
    parameter int WALK_CYC    = 2,
    parameter int GAP_CYC     = 4,
    parameter int RUNDOWN_CYC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disc_hit,
    input  logic               hold_valid,
    input  logic [AMP_W-1:0]   amp_code,
    input  logic [SCALE_W-1:0] runup_scale,
    output logic               wt_line,
    output logic               busy
);

    localparam int PROD_W = AMP_W + SCALE_W;
    localparam int RD_W   = $clog2(RUNDOWN_CYC) + 1;
    localparam int CNT_W  = (PROD_W > RD_W) ? PROD_W : RD_W;

    wte_state_t        state;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              capture;
    logic              cnt_zero;
    logic [PROD_W-1:0] prod;

    wte_ctrl #(
        .PROD_W      (PROD_W),
        .CNT_W       (CNT_W),
        .WALK_CYC    (WALK_CYC),
        .GAP_CYC     (GAP_CYC),
        .RUNDOWN_CYC (RUNDOWN_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .disc_hit   (disc_hit),
        .hold_valid (hold_valid),
        .cnt_zero   (cnt_zero),
        .prod       (prod),
        .state      (state),
        .load       (load),
        .load_val   (load_val),
        .capture    (capture),
        .wt_line    (wt_line),
        .busy       (busy)
    );

    wte_period_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .cnt_zero (cnt_zero)
    );

    wte_runup_calc #(
        .AMP_W   (AMP_W),
        .SCALE_W (SCALE_W)
    ) u_runup (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .amp_code    (amp_code),
        .runup_scale (runup_scale),
        .prod        (prod)
    );

    AST_LINE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wt_line |-> busy); // R7
    AST_IDLE_AFTER_RUNUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUNUP && cnt_zero) |=> (!busy && !wt_line)); // R7

endmodule

// File: tb/walk_time_encoder_test.sv
module walk_time_encoder_test;

    localparam int RD = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disc_hit = 1'b0;
    logic        hold_valid = 1'b0;
    logic [11:0] amp_code = '0;
    logic [3:0]  runup_scale = '0;
    logic        wt_line;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    walk_time_encoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .disc_hit    (disc_hit),
        .hold_valid  (hold_valid),
        .amp_code    (amp_code),
        .runup_scale (runup_scale),
        .wt_line     (wt_line),
        .busy        (busy)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog expired, got running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit exp_line(int c, int s, int n);
        return (c == 1 || c == 2) || (c > s && c <= s + RD + n);
    endfunction

    function automatic bit exp_busy(int c, int s, int n);
        return (c >= 1 && c <= s + RD + n);
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    // One event: hit at c=0, strobe at c=s (s>=7). early adds strobes in
    // walk/gap and a hit in gap; late adds strobe, hit and input changes mid-pulse.
    task automatic run_event(input logic [11:0] a, input logic [3:0] sc, input int s,
                             input bit early, input bit late, input string tag);
        int n = int'(a) * int'(sc);
        int last = s + RD + n + 3;
        int line_bad = -1;
        int busy_bad = -1;
        int width = 0;
        for (int c = 0; c <= last; c++) begin
            @(negedge clk);
            if (c >= 1) begin
                if (wt_line !== exp_line(c, s, n) && line_bad < 0) line_bad = c;
                if (busy !== exp_busy(c, s, n) && busy_bad < 0) busy_bad = c;
                if (c > 2 && wt_line === 1'b1) width++;
            end
            disc_hit    = (c == 0) || (early && c == 4) || (late && c == s + 5);
            hold_valid  = (c == s) || (early && (c == 1 || c == 4)) ||
                          (late && (c == s + 10 || c == s + RD + 1));
            amp_code    = (c == s) ? a : ~a;
            runup_scale = (c == s) ? sc : ~sc;
        end
        disc_hit   = 1'b0;
        hold_valid = 1'b0;
        check(tag, "first wt_line mismatch cycle (-1 none)", line_bad, -1);
        check(tag, "first busy mismatch cycle (-1 none)", busy_bad, -1);
        check(tag, "time pulse width", width, RD + n);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "wt_line in reset", int'(wt_line), 0);
        check("R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "wt_line after reset", int'(wt_line), 0);
        check("R1", "busy after reset", int'(busy), 0);

        // R9: strobe while idle has no effect
        hold_valid = 1'b1;
        amp_code = 12'd100;
        runup_scale = 4'd3;
        repeat (3) begin
            @(negedge clk);
            check("R9", "wt_line after idle strobe", int'(wt_line), 0);
            check("R9", "busy after idle strobe", int'(busy), 0);
        end
        hold_valid = 1'b0;

        // R2 R4 R7: basic event, earliest strobe
        run_event(12'd10, 4'd2, 7, 1'b0, 1'b0, "R2_R4_R7");
        // R6: zero amplitude and zero scale
        run_event(12'd0, 4'd9, 7, 1'b0, 1'b0, "R6 zero amp");
        run_event(12'd77, 4'd0, 9, 1'b0, 1'b0, "R6 zero scale");
        // R3: strobes in walk and gap ignored, hit in gap ignored
        run_event(12'd33, 4'd1, 11, 1'b1, 1'b0, "R3");
        // R8 R9: strobes, hit and input changes during pulse ignored
        run_event(12'd200, 4'd3, 8, 1'b0, 1'b1, "R8_R9");
        // R5: full-scale product
        run_event(12'd4095, 4'd15, 7, 1'b0, 1'b0, "R5 max");
        // R5: random amplitudes, scales and strobe delays
        for (int i = 0; i < 16; i++) begin
            logic [11:0] a  = 12'($urandom % 1024);
            logic [3:0]  sc = 4'($urandom % 4);
            int          s  = 7 + int'($urandom % 6);
            run_event(a, sc, s, bit'($urandom % 2), bit'($urandom % 2), "R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule